// File: doc/BRIEF.md
# Paged Non-Volatile Byte Store with Wrapping Address Counter

This block is the storage side of a two-wire serial memory. A protocol engine in front of it decodes the bus and drives it with four commands over a valid/ready handshake: set the address counter, write a byte, read a byte and commit. The core holds a 256 x 8 array split into 32 rows of 8 bytes, one address counter that survives between transactions, and an 8-lane staging buffer. A separate timer models the self-timed programming cycle.

Written bytes are first collected in the staging buffer and take effect only at the end of a write cycle. The write cycle is started by a commit command and lasts a set number of system clock cycles. During a write sequence the counter steps only inside the current row, so a long burst wraps around the row. During reads it steps across the whole array and wraps from the top to zero. A write-protect input causes incoming bytes to be dropped without any error.

Top module: `nvm_page_store`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are 0, `cmd_ready` is 1, the address counter is 0 and every array byte reads as 8'hFF.
- R2: A command is accepted on a rising clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_op` uses these codes: 0 = set address (taken from `cmd_data`), 1 = write byte, 2 = read byte, 3 = commit. An accepted read raises `rsp_valid` for exactly one cycle after that edge, and `rsp_data` then holds the array byte at the counter.
- R3: Each accepted read steps the counter by one across all 8 address bits, and address 255 wraps to 0.
- R4: Each accepted write steps only counter bits [2:0]. Bits [7:3] stay fixed, so lane 7 wraps to lane 0 of the same row. When more than 8 bytes are written, the last byte written to a lane is the one kept.
- R5: A commit updates only the lanes that received a byte since the last set-address command. The other bytes of the row keep their old values.
- R6: A commit with at least one staged byte holds `busy` high for exactly WR_CYCLES cycles, starting right after the accept edge. The array changes when `busy` falls.
- R7: A commit with no staged bytes starts no write cycle: `busy` stays 0 and the counter is unchanged.
- R8: A byte written while `wp` is 1 is dropped and the array keeps its old value. The counter still steps as in R4.
- R9: Between transactions the counter holds the address after the last byte accessed. A read with no set-address command before it returns the byte at that address.
- R10: A set-address command discards any staged bytes that have not been committed.
- R11: While `busy` is 1, `cmd_ready` is 0. No command is taken, `rsp_valid` stays 0 and the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Core can take a command (low while busy) |
| cmd_op | input | 2 | 0 set address, 1 write, 2 read, 3 commit |
| cmd_data | input | DATA_W | Address for op 0, write byte for op 1 |
| wp | input | 1 | Write protect; 1 drops incoming write bytes |
| busy | output | 1 | Programming cycle in progress |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_data | output | DATA_W | Byte returned by a read |

## Verification
The bench targets the two kinds of counter stepping. A design that stepped all 8 bits on writes would spill a 10-byte burst into the next row. A design that stepped only 3 bits on reads would wrap back to the start of the row instead of moving on to address 0 after 255. Partial rows are read back in full to catch a commit that writes all 8 lanes and overwrites the untouched bytes with stale data. Commits that are empty, follow protected writes only, or follow a discarded set-address must leave `busy` low, and a design that starts a cycle anyway shows up in the busy-length count. During a real write cycle the bench keeps a read request pending, to catch a core that accepts commands while busy.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   typedef enum logic [1:0] {
      OP_SETADDR = 2'd0,
      OP_WRITE   = 2'd1,
      OP_READ    = 2'd2,
      OP_COMMIT  = 2'd3
   } nvm_op_e;
endpackage

// File: rtl/nvm_addr_ctr.sv
module nvm_addr_ctr #(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step_row,
   input  logic              step_full,
   output logic [ADDR_W-1:0] addr
);
   generate
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_geom
         $error("nvm_addr_ctr: PAGE_W must be in 1..ADDR_W-1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr <= '0;
      else if (load_en)
         addr <= load_val;
      else if (step_full)
         addr <= addr + ADDR_W'(1);
      else if (step_row)
         addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
   end

   // R4: the row part of the counter stays fixed across a write step
   a_r4_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (step_row && !load_en && !step_full) |=>
         addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));
   // R3: a read step moves the full address by one, modulo the array size
   a_r3_full_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step_full && !load_en) |=> addr == $past(addr) + ADDR_W'(1));
   // R2: set-address takes the presented value
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> addr == $past(load_val));
endmodule

// File: rtl/nvm_page_buf.sv
module nvm_page_buf #(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 3,
   parameter int ROW_W  = 5
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   clr,
   input  logic                                   wr_en,
   input  logic [ROW_W-1:0]                       wr_row,
   input  logic [PAGE_W-1:0]                      wr_lane,
   input  logic [DATA_W-1:0]                      wr_data,
   output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]     lane_data,
   output logic [(1<<PAGE_W)-1:0]                 lane_mask,
   output logic [ROW_W-1:0]                       row
);
   localparam int LANES = 1 << PAGE_W;

   generate
      if (ROW_W < 1) begin : g_bad_row
         $error("nvm_page_buf: ROW_W must be at least 1");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lane_mask[g] <= 1'b0;
               lane_data[g] <= '0;
            end else if (clr) begin
               lane_mask[g] <= 1'b0;
            end else if (wr_en && wr_lane == PAGE_W'(g)) begin
               lane_mask[g] <= 1'b1;
               lane_data[g] <= wr_data;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         row <= '0;
      else if (wr_en && !clr)
         row <= wr_row;
   end

   // R10: a clear leaves no lane staged
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> lane_mask == '0);
   // R4: one write stages at most one new lane
   a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> $countones(lane_mask & ~$past(lane_mask)) <= 1);
endmodule

// File: rtl/nvm_commit_timer.sv
module nvm_commit_timer #(
   parameter int WR_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;

   generate
      if (WR_CYCLES < 1) begin : g_bad_len
         $error("nvm_commit_timer: WR_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] remain;

   assign done = busy && (remain == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            remain <= CW'(WR_CYCLES - 1);
         end
      end else if (remain == '0) begin
         busy <= 1'b0;
      end else begin
         remain <= remain - CW'(1);
      end
   end

   // R6: busy holds until the count is spent, then falls
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && remain != '0) |=> busy);
   a_r6_end: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
endmodule

// File: rtl/nvm_page_store.sv
module nvm_page_store #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int PAGE_W    = 3,
   parameter int WR_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              wp,
   output logic              busy,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);
   import nvm_pkg::*;

   localparam int DEPTH = 1 << ADDR_W;
   localparam int LANES = 1 << PAGE_W;
   localparam int ROW_W = ADDR_W - PAGE_W;

   generate
      if (DATA_W != ADDR_W) begin : g_bad_width
         $error("nvm_page_store: set-address needs DATA_W == ADDR_W");
      end
   endgenerate

   nvm_op_e op;
   logic    acc, is_set, is_wr, is_rd, is_cm;

   assign op        = nvm_op_e'(cmd_op);
   assign cmd_ready = !busy;
   assign acc       = cmd_valid && cmd_ready;
   assign is_set    = acc && op == OP_SETADDR;
   assign is_wr     = acc && op == OP_WRITE;
   assign is_rd     = acc && op == OP_READ;
   assign is_cm     = acc && op == OP_COMMIT;

   logic [ADDR_W-1:0] addr;

   nvm_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (is_set),
      .load_val  (cmd_data),
      .step_row  (is_wr),
      .step_full (is_rd),
      .addr      (addr)
   );

   logic [LANES-1:0][DATA_W-1:0] lane_data;
   logic [LANES-1:0]             lane_mask;
   logic [ROW_W-1:0]             stage_row;
   logic                         done;

   nvm_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .ROW_W(ROW_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (is_set || done),
      .wr_en     (is_wr && !wp),
      .wr_row    (addr[ADDR_W-1:PAGE_W]),
      .wr_lane   (addr[PAGE_W-1:0]),
      .wr_data   (cmd_data),
      .lane_data (lane_data),
      .lane_mask (lane_mask),
      .row       (stage_row)
   );

   nvm_commit_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (is_cm && |lane_mask),
      .busy  (busy),
      .done  (done)
   );

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (done) begin
         for (int l = 0; l < LANES; l++)
            if (lane_mask[l]) mem[{stage_row, PAGE_W'(l)}] <= lane_data[l];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= is_rd;
         if (is_rd) rsp_data <= mem[addr];
      end
   end

   // R2: an accepted read produces a response on the next cycle
   a_r2_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> rsp_valid);
   // R11: nothing is answered and the counter is frozen while busy
   a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !rsp_valid);
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(addr));
   // R7: an empty commit starts no cycle
   a_r7_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cm && lane_mask == '0) |=> !busy);
   // R8: a protected write stages nothing
   a_r8_wp: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && wp) |=> $stable(lane_mask));
endmodule

// File: tb/tb_nvm_page_store.sv
module tb_nvm_page_store;
   localparam int WR = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic [1:0] cmd_op = 2'd0;
   logic [7:0] cmd_data = 8'd0;
   logic       wp = 1'b0;
   logic       busy;
   logic       rsp_valid;
   logic [7:0] rsp_data;

   always #2.5 clk = ~clk;

   nvm_page_store #(.WR_CYCLES(WR)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_data(cmd_data), .wp(wp), .busy(busy),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data));

   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   logic [7:0] model [256];
   logic [7:0] s_buf [8];
   logic [7:0] s_mask;
   int         s_row, m_ctr;

   function automatic int next_wr(int a);
      return (a & 8'hF8) | ((a + 1) & 7);
   endfunction
   function automatic int next_rd(int a);
      return (a + 1) & 8'hFF;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic do_cmd(int op, int data);
      while (busy) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_data = 8'(data);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic set_addr(int a);
      do_cmd(0, a);
      m_ctr = a; s_mask = 8'h00;
   endtask

   task automatic wr(int d);
      do_cmd(1, d);
      if (!wp) begin
         s_buf[m_ctr & 7] = 8'(d);
         s_mask[m_ctr & 7] = 1'b1;
         s_row = m_ctr >> 3;
      end
      m_ctr = next_wr(m_ctr);
   endtask

   task automatic rd(string tag);
      do_cmd(2, 0);
      chk(rsp_valid && rsp_data == model[m_ctr], tag, {rsp_valid, rsp_data},
          {1'b1, model[m_ctr]});
      m_ctr = next_rd(m_ctr);
   endtask

   // hold_rd keeps a read request pending during the cycle (R11)
   task automatic commit(string tag, bit hold_rd);
      int n = 0, exp;
      bit leak = 0;
      exp = (s_mask != 0) ? WR : 0;
      do_cmd(3, 0);
      if (hold_rd && exp != 0) begin
         cmd_valid = 1'b1; cmd_op = 2'd2;
      end
      while (busy) begin
         if (rsp_valid || cmd_ready) leak = 1;
         n++;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      chk(n == exp, tag, n, exp);
      if (hold_rd) chk(!leak && !rsp_valid, "R11 busy accept", leak, 0);
      for (int l = 0; l < 8; l++)
         if (s_mask[l]) model[s_row * 8 + l] = s_buf[l];
      s_mask = 8'h00;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL R6 watchdog act=timeout exp=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int a, n, seed;
      seed = $urandom(32'h5EED_0042);
      for (int i = 0; i < 256; i++) model[i] = 8'hFF;
      s_mask = 8'h00; s_row = 0; m_ctr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && cmd_ready && !rsp_valid, "R1 reset outputs",
          {busy, cmd_ready, rsp_valid}, 3'b010);
      rd("R1 counter zero, erased byte");
      rd("R1 erased byte at 1");

      // R4/R5/R9: partial burst wrapping inside row 2
      set_addr(8'h15);
      wr(8'hA0); wr(8'hA1); wr(8'hA2); wr(8'hA3);
      commit("R6 busy length", 1);
      rd("R9 current address after row wrap");   // counter at 0x11
      set_addr(8'h10);
      do_cmd(2, 0);
      chk(rsp_data == 8'hA3, "R4 lane wrap to 0", rsp_data, 8'hA3);
      m_ctr = next_rd(m_ctr);
      for (int i = 1; i < 8; i++) rd("R5 partial row readback");
      rd("R4 next row untouched");

      // R4: ten bytes into row 7 overwrite lanes 0 and 1
      set_addr(8'h38);
      for (int i = 0; i < 10; i++) wr(8'hB0 + i);
      commit("R6 busy length long burst", 0);
      set_addr(8'h38);
      do_cmd(2, 0);
      chk(rsp_data == 8'hB8, "R4 overwrite lane 0", rsp_data, 8'hB8);
      m_ctr = next_rd(m_ctr);
      for (int i = 1; i < 9; i++) rd("R4 burst readback");

      // R3: read wrap at top of array
      set_addr(8'hFE);
      for (int i = 0; i < 4; i++) rd("R3 full wrap");

      // R7: empty commit
      set_addr(8'h40);
      commit("R7 empty commit no busy", 0);
      rd("R7 counter unchanged");

      // R8: protected writes are dropped, counter still steps
      set_addr(8'h60);
      wp = 1'b1;
      wr(8'h11); wr(8'h22); wr(8'h33);
      wp = 1'b0;
      commit("R8 protected commit idle", 0);
      rd("R8 counter stepped to 0x63");
      set_addr(8'h60);
      rd("R8 array unchanged");

      // R10: set-address discards staged bytes
      set_addr(8'h70);
      wr(8'h5A); wr(8'h5B);
      set_addr(8'h80);
      commit("R10 discarded staging idle", 0);
      set_addr(8'h70);
      rd("R10 array unchanged");

      // random mix
      for (int it = 0; it < 40; it++) begin
         a = $urandom % 256;
         set_addr(a);
         n = $urandom % 12;
         wp = (($urandom % 5) == 0);
         for (int j = 0; j < n; j++) wr($urandom % 256);
         wp = 1'b0;
         commit("R6 random commit", it % 3 == 0);
         rd("R9 random current read");
         set_addr($urandom % 256);
         n = ($urandom % 10) + 1;
         for (int j = 0; j < n; j++) rd("R3 random read");
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule